// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block turns a wide duty word into a single-bit output whose long-run average matches that word. The word splits in two. The upper CNT_W bits set the compare value of a counter-compare PWM whose period is 2^CNT_W ticks. The lower FRAC_W bits feed a first-order delta-sigma accumulator that steps once per period. Whenever the accumulator overflows, the period that is starting gets one extra high tick. The output therefore moves between two adjacent coarse levels, and it gains FRAC_W bits of resolution without a longer period.

A mode pin selects how the high ticks sit inside a period. In linear order they form one block at the start of the period. In scattered order the counter is compared with its bits reversed, which spreads the same number of high ticks evenly across the period and moves the ripple to a much higher frequency for the downstream filter. The tick enable is a plain clock enable that sets the PWM tick rate. The duty word and the mode are plain level inputs, sampled only at period boundaries. There is no handshake: a new value is picked up at the next period start and applies to that whole period.

Top module: `dpwm_gen`

## Requirements
- R1: Every period is exactly 2^CNT_W enabled ticks long. `period_start` is high for the output sample of the first tick of each period and low for every other tick.
- R2: Reset is synchronous and active high. While it is held, `pwm_out` and `period_start` are low. It clears the tick counter and the accumulator to zero, so the first tick after reset starts a new period.
- R3: Write F for the low FRAC_W bits and C for the upper CNT_W bits of the duty word. Period p after reset (p = 0, 1, ...) has exactly C + floor((p+1)·F/2^FRAC_W) − floor(p·F/2^FRAC_W) high ticks. Over any 2^FRAC_W consecutive periods, the total number of high ticks equals the full duty word.
- R4: When C is all ones and the accumulator carries, the output is high for every tick of that period. It does not wrap to zero.
- R5: With `rev_mode` = 0, the output for tick k of a period (k = 0 .. 2^CNT_W−1) is high exactly when k is less than that period's compare value.
- R6: With `rev_mode` = 1, the output for tick k is high exactly when the bit-reversed k is less than the compare value. At 50% duty this gives high, low, high, low on successive ticks.
- R7: `duty` and `rev_mode` are sampled only at the first tick of a period. A change in the middle of a period leaves the rest of that period unchanged.
- R8: While `tick_en` is low, the counter, the accumulator and `pwm_out` hold, and `period_start` stays low.
- R9: The output for each tick is registered. It appears one clock after the enabled edge that processes that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Clock enable; one PWM tick per enabled cycle |
| duty | input | CNT_W+FRAC_W | Duty word: upper CNT_W bits are the coarse level, lower FRAC_W bits are the dither fraction |
| rev_mode | input | 1 | 0 = high ticks in one block, 1 = high ticks spread by bit-reversed comparison |
| pwm_out | output | 1 | Registered PWM output |
| period_start | output | 1 | High with the output sample of the first tick of each period |

## Verification
The bench uses a small 4+3-bit configuration. It sweeps every duty word in both orderings and predicts each period's high count and tick-by-tick pattern from the arithmetic above. It catches the following faults:
- An accumulator that carries into the wrong period, or one not cleared by reset, gives a wrong per-period count.
- A compare value that wraps at the all-ones level gives an empty period where a full one is due.
- A reversal wired the wrong way round breaks the alternating 50% pattern.
- Sampling duty or mode mid-period shows up as a truncated or reshaped pulse.
- A tick enable that fails to freeze the counter shows up as a moved output or a missing or extra strobe during a stall.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic {
    ORDER_LINEAR   = 1'b0,
    ORDER_REVERSED = 1'b1
  } order_e;
endpackage

// File: rtl/dpwm_period_ctr.sv
module dpwm_period_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt,
  output logic             load
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign load = tick_en && (cnt_q == '0);

  // R1: the last tick of a period is followed by the first tick of the next
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick_en && cnt_q == CNT_MAX) |=> (cnt_q == '0));
  // R8: no enable, no movement
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/dpwm_frac_acc.sv
module dpwm_frac_acc #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_d;

  assign {carry, acc_d} = {1'b0, acc_q} + {1'b0, frac};

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (load) acc_q <= acc_d;
  end

  // R3: the accumulator steps only at a period boundary
  p_acc_step_r3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(acc_q));
endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             load,
  input  logic [CNT_W-1:0] coarse,
  input  logic             carry,
  input  logic             rev_mode,
  input  logic [CNT_W-1:0] cnt,
  output logic             pwm_out,
  output logic             period_start
);
  localparam int CMP_W = CNT_W + 1;

  logic [CMP_W-1:0] live_cmp;
  logic [CMP_W-1:0] cmp_q;
  logic [CMP_W-1:0] cmp_sel;
  order_e           order_q;
  order_e           order_sel;
  logic [CNT_W-1:0] cnt_rev;
  logic [CNT_W-1:0] pos;

  // one extra bit so that all-ones plus a carry saturates instead of wrapping
  assign live_cmp = {1'b0, coarse} + {{CNT_W{1'b0}}, carry};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '0;
      order_q <= ORDER_LINEAR;
    end else if (load) begin
      cmp_q   <= live_cmp;
      order_q <= order_e'(rev_mode);
    end
  end

  // the first tick of a period uses the freshly sampled values
  assign cmp_sel   = load ? live_cmp : cmp_q;
  assign order_sel = load ? order_e'(rev_mode) : order_q;

  for (genvar i = 0; i < CNT_W; i++) begin : g_rev
    assign cnt_rev[i] = cnt[CNT_W-1-i];
  end

  assign pos = (order_sel == ORDER_REVERSED) ? cnt_rev : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out      <= 1'b0;
      period_start <= 1'b0;
    end else begin
      period_start <= load;
      if (tick_en) pwm_out <= (cmp_sel > {1'b0, pos});
    end
  end

  // R2: reset forces both outputs low
  p_reset_low_r2: assert property (@(posedge clk)
    rst |=> (!pwm_out && !period_start));
  // R4: a saturated compare value yields a high tick
  p_saturate_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_en && cmp_sel[CNT_W]) |=> pwm_out);
  // R3: a zero compare value yields a low tick
  p_zero_low_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && cmp_sel == '0) |=> !pwm_out);
  // R7: held values change only at a period boundary
  p_capture_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(cmp_q) && $stable(order_q)));
  // R8: the output freezes while ticks are paused
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(pwm_out) && !period_start));
endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen #(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_en,
  input  logic [CNT_W+FRAC_W-1:0] duty,
  input  logic                    rev_mode,
  output logic                    pwm_out,
  output logic                    period_start
);
  localparam int DUTY_W = CNT_W + FRAC_W;

  logic [CNT_W-1:0] cnt;
  logic             load;
  logic             carry;

  dpwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .cnt     (cnt),
    .load    (load)
  );

  dpwm_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .frac  (duty[FRAC_W-1:0]),
    .carry (carry)
  );

  dpwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .load         (load),
    .coarse       (duty[DUTY_W-1:FRAC_W]),
    .carry        (carry),
    .rev_mode     (rev_mode),
    .cnt          (cnt),
    .pwm_out      (pwm_out),
    .period_start (period_start)
  );

  // R1: the strobe is a single-cycle pulse when ticks run back to back
  p_strobe_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    (period_start && $past(tick_en)) |=> !period_start);
endmodule

// File: tb/test_dpwm_gen.sv
module test_dpwm_gen;
  localparam int N  = 4;
  localparam int M  = 3;
  localparam int DW = N + M;
  localparam int TICKS = 1 << N;
  localparam int PERS  = 1 << M;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic [DW-1:0] duty = '0;
  logic          rev_mode = 1'b0;
  logic          pwm_out;
  logic          period_start;

  int n_total = 0;
  int n_pass  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dpwm_gen #(.CNT_W(N), .FRAC_W(M)) i_dpwm_gen (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .duty         (duty),
    .rev_mode     (rev_mode),
    .pwm_out      (pwm_out),
    .period_start (period_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  function automatic int rev_bits(input int k);
    int r = 0;
    for (int i = 0; i < N; i++) if (k[i]) r |= 1 << (N - 1 - i);
    return r;
  endfunction

  function automatic int expect_highs(input int d, input int p);
    int c = d >> M;
    int f = d & (PERS - 1);
    return c + ((p + 1) * f) / PERS - (p * f) / PERS;
  endfunction

  task automatic start(input int d, input bit m);
    duty = DW'(d);
    rev_mode = m;
    tick_en = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // entered at the negedge holding tick 0's output; leaves at the next period's tick 0
  task automatic do_period(input int e, input bit rev, input int chg_at, input int nd,
                           input bit nm, input int stall_at, output int highs,
                           output int patbad, output int strbad, output int stallbad);
    highs = 0; patbad = 0; strbad = 0; stallbad = 0;
    for (int k = 0; k < TICKS; k++) begin
      bit exp_v = rev ? (rev_bits(k) < e) : (k < e);
      if (pwm_out === 1'b1) highs++;
      if (pwm_out !== exp_v) patbad++;
      if (period_start !== (k == 0)) strbad++;
      if (k == chg_at) begin
        duty = DW'(nd);
        rev_mode = nm;
      end
      if (k == stall_at) begin
        logic held = pwm_out;
        tick_en = 1'b0;
        repeat (6) begin
          @(negedge clk);
          if (pwm_out !== held || period_start !== 1'b0) stallbad++;
        end
        tick_en = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_case(input int d, input bit m);
    int highs, patbad, strbad, stallbad, sum = 0, cntbad = 0, pbad = 0, sbad = 0;
    int e, first_bad_act = 0, first_bad_exp = 0;
    bool_sat: begin end
    start(d, m);
    for (int p = 0; p < PERS; p++) begin
      e = expect_highs(d, p);
      do_period(e, m, -1, 0, 1'b0, -1, highs, patbad, strbad, stallbad);
      sum += highs;
      pbad += patbad;
      sbad += strbad;
      if (highs != e) begin
        if (cntbad == 0) begin first_bad_act = highs; first_bad_exp = e; end
        cntbad++;
      end
      if (e == TICKS) check(highs == TICKS, "R4 saturated period", highs, TICKS);
    end
    check(cntbad == 0, "R3 per-period high count", first_bad_act, first_bad_exp);
    check(sum == d, "R3 total over dither cycle", sum, d);
    check(sbad == 0, "R1 strobe position", sbad, 0);
    if (m) check(pbad == 0, "R6 reversed pattern", pbad, 0);
    else   check(pbad == 0, "R5 linear pattern", pbad, 0);
  endtask

  initial begin
    int highs, patbad, strbad, stallbad, ones;

    // R2: reset state
    repeat (2) @(negedge clk);
    check(pwm_out === 1'b0, "R2 pwm low in reset", pwm_out, 0);
    check(period_start === 1'b0, "R2 strobe low in reset", period_start, 0);

    // R8: idle ticks after reset produce nothing
    duty = DW'(100);
    rst = 1'b0;
    tick_en = 1'b0;
    ones = 0;
    repeat (10) begin
      @(negedge clk);
      if (pwm_out !== 1'b0 || period_start !== 1'b0) ones++;
    end
    check(ones == 0, "R8 idle after reset", ones, 0);

    // R6: 50% in reversed order alternates every tick; R9 first sample one clock after tick
    start(8 << M, 1'b1);
    check(period_start === 1'b1, "R9 strobe one clock after first tick", period_start, 1);
    ones = 0;
    for (int k = 0; k < TICKS; k++) begin
      if (pwm_out !== ((k % 2) == 0)) ones++;
      @(negedge clk);
    end
    check(ones == 0, "R6 half duty alternates", ones, 0);

    // R7: mid-period change of duty and mode is ignored until the next period
    start(12 << M, 1'b0);
    do_period(12, 1'b0, 5, 0, 1'b1, -1, highs, patbad, strbad, stallbad);
    check(highs == 12, "R7 period keeps sampled duty", highs, 12);
    check(patbad == 0, "R7 period keeps sampled order", patbad, 0);
    do_period(0, 1'b1, -1, 0, 1'b0, -1, highs, patbad, strbad, stallbad);
    check(highs == 0 && strbad == 0, "R7 new duty in next period", highs, 0);

    // R8: a stall inside a period freezes the output
    start(10 << M, 1'b0);
    do_period(10, 1'b0, -1, 0, 1'b0, 6, highs, patbad, strbad, stallbad);
    check(stallbad == 0, "R8 stall holds output", stallbad, 0);
    check(highs == 10 && patbad == 0, "R8 period intact after stall", highs, 10);
    check(strbad == 0 && period_start === 1'b1, "R1 strobe after stalled period", strbad, 0);

    // R2: reset mid-run clears outputs and restarts the dither sequence
    start(7 << M | 5, 1'b0);
    repeat (21) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(pwm_out === 1'b0 && period_start === 1'b0, "R2 reset mid-period", pwm_out, 0);

    // exhaustive sweep of duty words in both orders
    for (int m = 0; m < 2; m++)
      for (int d = 0; d < (1 << DW); d++)
        run_case(d, m[0]);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end
endmodule